// File: doc/BRIEF.md
# Carry-Save Radix-2 Montgomery Multiplier

This block forms the Montgomery product of two k-bit operands A and B with respect to an odd k-bit modulus N. It retires one multiplier bit per clock. The running sum is kept in redundant form as two vectors, and a carry-save stage updates them each cycle, so no long carry chain sits in the iteration loop. After k+2 iterations a single carry-propagate add folds the two vectors into a binary result of k+1 bits.

No comparison against N and no final subtraction take place. Because the loop runs two extra iterations, the result stays small enough to be fed straight back as an operand of a later product, as happens in a modular exponentiation sequencer. Montgomery constants are computed elsewhere.

Each cycle two candidate quotient bits are computed from the low bits of the redundant sum. The current multiplier bit picks one of them. That bit and the chosen quotient bit then steer a single four-way mux, which selects 0, N, B or a precomputed B+N as the addend.

Top module: `mont_csa_mul`

## Requirements
- R1: While reset is asserted, and directly after it, `done` is 0 and `result` is 0.
- R2: A `start` pulse seen on a rising edge while the block is idle captures `a_in`, `b_in` and `n_in`. Changes on these inputs after that edge have no effect on the product being computed.
- R3: `result` equals S(k+2). Here S(0)=0, and for i=0..k+1, S(i+1) = (S(i) + a_i*B + q_i*N)/2, where a_i is bit i of A (bits at or above k are 0) and q_i is chosen so that the dividend is even. No subtraction of N follows.
- R4: `result` * 2^(k+2) is congruent to A*B modulo N.
- R5: `result` is strictly less than N+B.
- R6: `done` is 1 in exactly the cycle after the (k+3)-th rising edge that follows the accepting edge, and 0 in the cycles before it.
- R7: `done` stays high for one cycle only. `result` changes only in the cycle where `done` rises and holds its value until the next product completes.
- R8: A `start` seen on any of the k+3 rising edges that follow an accepting edge is ignored. It does not alter the product in progress or its completion time. A `start` seen while `done` is high is accepted.
- R9: The quotient bit is bit0(S1) XOR bit0(S2) when a_i=0, and that value XOR bit0(B) when a_i=1. With this choice the sum of S1, S2 and the addend is even in every iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a product when idle |
| a_in | input | WIDTH | Multiplier operand A |
| b_in | input | WIDTH | Multiplicand operand B |
| n_in | input | WIDTH | Odd modulus N |
| result | output | WIDTH+1 | Binary Montgomery product, not reduced |
| done | output | 1 | One-cycle completion pulse |

## Verification
With k=5, every A and B from 0 to 31 is tried against every odd modulus from 17 to 31. The exact iterative value separates a wrong quotient choice or addend selection from a result that is merely congruent. The congruence and bound checks separate a wrong iteration count from a wrong carry alignment. Runs are issued back to back with start raised while done is high. A separate run changes the operand inputs and pulses start in mid-product and in the final cycle, which tells operand capture and start rejection apart from the timing of done and the holding of the result.

// File: rtl/mont_csa_mul.sv
module mont_csa_mul #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] n_in,
  output logic [WIDTH:0]   result,
  output logic             done
);
  localparam int W    = WIDTH + 2;
  localparam int CW   = $clog2(WIDTH + 2);
  localparam int LAST = WIDTH + 1;

  logic [WIDTH-1:0] a_reg;
  logic [W-1:0]     b_reg, n_reg, bn_reg;
  logic [W-1:0]     s1, s2;
  logic [CW-1:0]    cnt;
  logic             busy, fin;

  logic             q0, q1, q;
  logic [W-1:0]     addend, csa_s, csa_c;

  wire accept = start && !busy && !fin;

  assign q0 = s1[0] ^ s2[0];
  assign q1 = q0 ^ b_reg[0];
  assign q  = a_reg[0] ? q1 : q0;

  always_comb begin
    case ({a_reg[0], q})
      2'b00:   addend = '0;
      2'b01:   addend = n_reg;
      2'b10:   addend = b_reg;
      default: addend = bn_reg;
    endcase
  end

  assign csa_s = s1 ^ s2 ^ addend;
  assign csa_c = ((s1 & s2) | (s1 & addend) | (s2 & addend)) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_reg  <= '0;
      b_reg  <= '0;
      n_reg  <= '0;
      bn_reg <= '0;
      s1     <= '0;
      s2     <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      fin    <= 1'b0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      fin  <= 1'b0;
      if (accept) begin
        a_reg  <= a_in;
        b_reg  <= W'(b_in);
        n_reg  <= W'(n_in);
        bn_reg <= W'(b_in) + W'(n_in);
        s1     <= '0;
        s2     <= '0;
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        s1    <= csa_s >> 1;
        s2    <= csa_c >> 1;
        a_reg <= a_reg >> 1;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(LAST)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        result <= (WIDTH+1)'(s1 + s2);
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mont_csa_mul_chk.sv
module mont_csa_mul_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [WIDTH:0]   result,
  input logic [WIDTH+1:0] b_reg,
  input logic [WIDTH+1:0] n_reg,
  input logic [WIDTH+1:0] s1,
  input logic [WIDTH+1:0] s2,
  input logic [WIDTH+1:0] addend
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((WIDTH+2)'(result) < b_reg + n_reg));

  assert_even_total_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(s1[0] ^ s2[0] ^ addend[0]));

  assert_ops_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(b_reg) && $stable(n_reg)));
endmodule

bind mont_csa_mul mont_csa_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .b_reg(b_reg), .n_reg(n_reg), .s1(s1), .s2(s2), .addend(addend)
);

// File: tb/mont_csa_mul_test.sv
module mont_csa_mul_test;
  localparam int K  = 5;
  localparam int RK = 1 << (K + 2);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] a = '0, b = '0, n = '0;
  logic [K:0]   result;
  logic         done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  mont_csa_mul #(.WIDTH(K)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_in(a), .b_in(b), .n_in(n), .result(result), .done(done)
  );

  always #5 clk = ~clk;

  function automatic int ref_mont(int av, int bv, int nv);
    int s = 0;
    for (int i = 0; i < K + 2; i++) begin
      if (((av >> i) & 1) == 1) s += bv;
      if ((s & 1) == 1) s += nv;
      s = s / 2;
    end
    return s;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Called at a negedge; start is accepted at the next posedge.
  task automatic run(int av, int bv, int nv, output int res);
    int early = 0;
    a = K'(av); b = K'(bv); n = K'(nv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= K + 3; c++) begin
      @(negedge clk);
      if (c < K + 3 && done) early++;
    end
    check(early == 0 && done == 1'b1, "R6 done timing", int'(done), 1);
    res = int'(result);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int res, e;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 reset state", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 after release", int'(result), 0);

    // Exhaustive sweep, back to back (start raised while done is high)
    for (int nv = 17; nv < 32; nv += 2)
      for (int av = 0; av < 32; av++)
        for (int bv = 0; bv < 32; bv++) begin
          run(av, bv, nv, res);
          e = ref_mont(av, bv, nv);
          check(res == e, "R3/R9 exact product", res, e);
          check(((res * RK) % nv) == ((av * bv) % nv), "R4 congruence",
                (res * RK) % nv, (av * bv) % nv);
          check(res < nv + bv, "R5 bound", res, nv + bv);
        end

    // R7: hold with idle inputs changing
    @(negedge clk);
    check(done == 1'b0, "R7 single pulse", int'(done), 0);
    e = int'(result);
    for (int c = 0; c < 6; c++) begin
      a = K'(c * 7); b = K'(c * 3); n = K'(c * 5 + 1);
      @(negedge clk);
      check(done == 1'b0 && int'(result) == e, "R7 hold", int'(result), e);
    end

    // R2/R8: operand changes and start pulses during a product
    a = K'(27); b = K'(19); n = K'(23); start = 1'b1;
    @(negedge clk);
    a = K'(4); b = K'(9); n = K'(29);
    for (int c = 1; c <= K + 3; c++) begin
      start = (c == 2 || c == K + 2) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (c < K + 3)
        check(done == 1'b0, "R8 no early done", int'(done), 0);
    end
    start = 1'b0;
    e = ref_mont(27, 19, 23);
    check(done == 1'b1, "R8 completion time kept", int'(done), 1);
    check(int'(result) == e, "R2/R8 captured operands used", int'(result), e);
    @(negedge clk);
    check(done == 1'b0 && int'(result) == e, "R8 no second product", int'(result), e);
    repeat (K + 4) @(negedge clk);
    check(done == 1'b0 && int'(result) == e, "R7 hold after ignored start", int'(result), e);

    // R8: start while done is high is accepted
    run(3, 5, 31, res);
    a = K'(6); b = K'(7); n = K'(17); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= K + 3; c++) @(negedge clk);
    e = ref_mont(6, 7, 17);
    check(done == 1'b1 && int'(result) == e, "R8 start during done accepted", int'(result), e);

    finish_up();
  end
endmodule